// File: doc/BRIEF.md
# Programmable System Clock Controller

This block turns a set of per-source rate ticks into one system clock-enable strobe. Everything runs on a single real clock. Each tick input is a one-cycle pulse at the rate of a notional oscillator. The block selects one of these sources, can pass it through a modelled frequency-multiplying loop, and can apply a programmable system divider. The result is a strobe that downstream logic uses as its clock enable.

Software programs two configuration words. The second word, when its override bit is set, takes over source selection, the divider, bypass and power-down from the first. A third word sets the loop multiplier F and the reference divider R. A fourth address holds the latched lock status, which software clears by writing one. The loop is modelled as a lock timer that counts reference ticks, plus a credit-based rate generator. A bypass that software has cleared is still forced on until lock is present, so an unlocked rate never reaches the output.

Top module: `sclk_ctrl`

## Requirements
- R1: When bit 31 of the second configuration word (address 1) is set, the source select in bits [4:2], the divider in bits [21:16], bypass in bit 0 and power-down in bit 1 all come from that word. Otherwise they come from the first configuration word (address 0): bypass bit 0, power-down bit 1, source bits [4:3] and divider bits [15:12]. The use-divider bit 2 and the crystal-value field bits [8:5] always come from address 0.
- R2: Source codes are 0 for the crystal tick, 1 for the internal tick, 2 for the internal tick divided by 4 and 3 for the 30 kHz tick. In the second word, codes 4 to 7 select the 32 kHz tick. With bypass in effect and no division, each source tick produces one output strobe.
- R3: With the loop in use, the loop rate is the reference tick rate times F divided by (R+1). F is in bits [7:0] and R in bits [12:8] of address 2.
- R4: On the loop path the loop rate is halved before the system divider.
- R5: When the use-divider bit is set, the strobe rate is the pre-divider rate divided by (divider field + 1). When it is clear, the divider field has no effect.
- R6: Power-down set holds the loop unlocked. After power-down clears, lock is reached after LOCK_TICKS reference ticks. Lock sets the raw status (address 3, bit 0), and lock_irq_o follows that status.
- R7: Writing 1 to bit 0 of address 3 clears the lock status. Writing 0 leaves it unchanged.
- R8: While the loop is unlocked, the strobe comes from the raw source even if bypass is clear.
- R9: A change of the effective source or of the crystal-value field drops lock and restarts the lock count.
- R10: A new divider value takes effect only at an output strobe, so the period in progress completes at its old length.
- R11: After reset, sys_en_o and lock_irq_o are low. Addresses 0 to 3 read back 0x0000000B, 0x00000003, 0x00000001 and 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| tick_xtal_i | input | 1 | Crystal oscillator rate tick |
| tick_int_i | input | 1 | Internal 12 MHz oscillator rate tick |
| tick_lf30_i | input | 1 | 30 kHz oscillator rate tick |
| tick_lf32_i | input | 1 | 32 kHz oscillator rate tick |
| sys_en_o | output | 1 | System clock-enable strobe |
| lock_irq_o | output | 1 | Latched loop-lock interrupt |

## Verification
A wrong select or divider state shows up as a wrong strobe count within one output period. The bench counts strobes against the ticks of the chosen source over windows of a few hundred cycles. A lock timer that does not restart, or a lock that is never forced, shows as a wrong strobe rate or a missing interrupt within about LOCK_TICKS reference ticks. A divider that loads too early shows as a short period at the very first strobe after the write.

// File: rtl/sclk_pkg.sv
// Shared constants for the system clock controller: register addresses,
// field positions and source codes. Assumes 32-bit register words.
package sclk_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int DIV_A_W  = 4;
    localparam int DIV_B_W  = 6;
    localparam int XTAL_W   = 4;
    localparam int MUL_W    = 8;
    localparam int REF_W    = 5;

    localparam logic [ADDR_W-1:0] ADDR_CFG_A = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG_B = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_LOOP  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd3;

    localparam int A_BYP  = 0;
    localparam int A_PD   = 1;
    localparam int A_UDIV = 2;
    localparam int A_SRC  = 3;
    localparam int A_XTAL = 5;
    localparam int A_DIV  = 12;

    localparam int B_BYP  = 0;
    localparam int B_PD   = 1;
    localparam int B_SRC  = 2;
    localparam int B_DIV  = 16;
    localparam int B_OVR  = 31;

    localparam int L_MUL  = 0;
    localparam int L_REF  = 8;

    typedef enum logic [2:0] {
        SRC_XTAL  = 3'd0,
        SRC_INT   = 3'd1,
        SRC_INT4  = 3'd2,
        SRC_LF30  = 3'd3,
        SRC_LF32  = 3'd4
    } src_e;
endpackage

// File: rtl/sclk_regs.sv
// Register file: two configuration words, loop word and latched lock status.
// Assumes single-cycle writes; reads are combinational on the address.
module sclk_regs
    import sclk_pkg::*;
#(
    parameter int DIV_AW = DIV_A_W,
    parameter int DIV_BW = DIV_B_W,
    parameter int XW     = XTAL_W,
    parameter int FW     = MUL_W,
    parameter int RW     = REF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              lock_set,
    output logic              a_byp,
    output logic              a_pd,
    output logic              a_udiv,
    output logic [1:0]        a_src,
    output logic [XW-1:0]     a_xtal,
    output logic [DIV_AW-1:0] a_div,
    output logic              b_ovr,
    output logic              b_byp,
    output logic              b_pd,
    output logic [2:0]        b_src,
    output logic [DIV_BW-1:0] b_div,
    output logic [FW-1:0]     mul_f,
    output logic [RW-1:0]     ref_r,
    output logic              lock_sts
);
    // Configuration word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_byp  <= 1'b1;
            a_pd   <= 1'b1;
            a_udiv <= 1'b0;
            a_src  <= 2'd1;
            a_xtal <= '0;
            a_div  <= '0;
            b_ovr  <= 1'b0;
            b_byp  <= 1'b1;
            b_pd   <= 1'b1;
            b_src  <= '0;
            b_div  <= '0;
            mul_f  <= FW'(1);
            ref_r  <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CFG_A: begin
                    a_byp  <= wdata[A_BYP];
                    a_pd   <= wdata[A_PD];
                    a_udiv <= wdata[A_UDIV];
                    a_src  <= wdata[A_SRC +: 2];
                    a_xtal <= wdata[A_XTAL +: XW];
                    a_div  <= wdata[A_DIV +: DIV_AW];
                end
                ADDR_CFG_B: begin
                    b_byp  <= wdata[B_BYP];
                    b_pd   <= wdata[B_PD];
                    b_src  <= wdata[B_SRC +: 3];
                    b_div  <= wdata[B_DIV +: DIV_BW];
                    b_ovr  <= wdata[B_OVR];
                end
                ADDR_LOOP: begin
                    mul_f  <= wdata[L_MUL +: FW];
                    ref_r  <= wdata[L_REF +: RW];
                end
                default: ;
            endcase
        end
    end

    // Latched lock status: a set from the lock timer wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_sts <= 1'b0;
        else if (lock_set)
            lock_sts <= 1'b1;
        else if (we && addr == ADDR_STAT && wdata[0])
            lock_sts <= 1'b0;
    end

    // Read-back multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CFG_A: begin
                rdata[A_BYP]          = a_byp;
                rdata[A_PD]           = a_pd;
                rdata[A_UDIV]         = a_udiv;
                rdata[A_SRC +: 2]     = a_src;
                rdata[A_XTAL +: XW]   = a_xtal;
                rdata[A_DIV +: DIV_AW] = a_div;
            end
            ADDR_CFG_B: begin
                rdata[B_BYP]          = b_byp;
                rdata[B_PD]           = b_pd;
                rdata[B_SRC +: 3]     = b_src;
                rdata[B_DIV +: DIV_BW] = b_div;
                rdata[B_OVR]          = b_ovr;
            end
            ADDR_LOOP: begin
                rdata[L_MUL +: FW]    = mul_f;
                rdata[L_REF +: RW]    = ref_r;
            end
            default: rdata[0] = lock_sts;
        endcase
    end
endmodule

// File: rtl/sclk_src_sel.sv
// Source selector: picks one tick stream and derives the divided internal
// tick. Assumes every input tick is a single-cycle pulse.
module sclk_src_sel
    import sclk_pkg::*;
#(
    parameter int INT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e sel,
    input  logic t_xtal,
    input  logic t_int,
    input  logic t_lf30,
    input  logic t_lf32,
    output logic src_tick
);
    localparam int CW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

    logic [CW-1:0] icnt_q;
    logic          t_int4;

    // Free-running prescaler on the internal tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            icnt_q <= '0;
        else if (t_int)
            icnt_q <= (icnt_q == CW'(INT_DIV - 1)) ? '0 : icnt_q + 1'b1;
    end

    assign t_int4 = t_int && (icnt_q == CW'(INT_DIV - 1));

    // Tick multiplexer
    always_comb begin
        case (sel)
            SRC_XTAL: src_tick = t_xtal;
            SRC_INT:  src_tick = t_int;
            SRC_INT4: src_tick = t_int4;
            SRC_LF30: src_tick = t_lf30;
            default:  src_tick = t_lf32;
        endcase
    end
endmodule

// File: rtl/sclk_loop_model.sv
// Frequency-multiplying loop model: a lock timer on reference ticks and a
// credit accumulator that emits ticks at ref*F/(R+1), at most one per cycle.
// Assumes the multiplied rate stays at or below the clock rate; excess
// credit saturates.
module sclk_loop_model #(
    parameter int FW         = 8,
    parameter int RW         = 5,
    parameter int KEY_W      = 7,
    parameter int LOCK_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             pd,
    input  logic [KEY_W-1:0] key,
    input  logic [FW-1:0]    mul_f,
    input  logic [RW-1:0]    ref_r,
    output logic             loop_tick,
    output logic             locked,
    output logic             lock_rise
);
    localparam int LCW = $clog2(LOCK_TICKS + 1);
    localparam int CRW = FW + RW;

    logic [KEY_W-1:0] key_q;
    logic [LCW-1:0]   lcnt_q;
    logic [CRW-1:0]   cred_q;
    logic [CRW:0]     cred_sum;
    logic [CRW-1:0]   den;
    logic             restart;

    assign restart   = pd || (key != key_q);
    assign den       = CRW'(ref_r) + CRW'(1);
    assign lock_rise = !locked && !restart && ref_tick &&
                       (lcnt_q == LCW'(LOCK_TICKS - 1));
    assign loop_tick = locked && (cred_q >= den);

    // Remember the previous source/crystal key to detect changes
    always_ff @(posedge clk) begin
        if (!rst_n) key_q <= key;
        else        key_q <= key;
    end

    // Lock timer counting reference ticks
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            lcnt_q <= '0;
            locked <= 1'b0;
        end else if (lock_rise) begin
            locked <= 1'b1;
        end else if (!locked && ref_tick) begin
            lcnt_q <= lcnt_q + 1'b1;
        end
    end

    // Credit update: add F per reference tick, spend R+1 per loop tick
    always_comb begin
        cred_sum = {1'b0, cred_q};
        if (locked && ref_tick) cred_sum = cred_sum + (CRW + 1)'(mul_f);
        if (loop_tick)          cred_sum = cred_sum - {1'b0, den};
    end

    // Credit register with saturation
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !locked)
            cred_q <= '0;
        else if (cred_sum[CRW])
            cred_q <= '1;
        else
            cred_q <= cred_sum[CRW-1:0];
    end
endmodule

// File: rtl/sclk_sysdiv.sv
// System divider: optional halving on the loop path, then divide by
// (value+1). A new divider value is loaded only when a strobe is emitted.
module sclk_sysdiv #(
    parameter int DW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_tick,
    input  logic          loop_tick,
    input  logic          use_loop,
    input  logic          use_div,
    input  logic [DW-1:0] div,
    output logic          pre_tick,
    output logic          sys_en
);
    logic          half_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] act_q;
    logic [DW-1:0] next_div;

    assign pre_tick = use_loop ? (loop_tick && half_q) : src_tick;
    assign next_div = use_div ? div : '0;

    // Halving toggle on loop ticks
    always_ff @(posedge clk) begin
        if (!rst_n)         half_q <= 1'b0;
        else if (loop_tick) half_q <= !half_q;
    end

    // Divider counter with boundary-only reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            act_q  <= '0;
            sys_en <= 1'b0;
        end else if (pre_tick) begin
            if (cnt_q == act_q) begin
                cnt_q  <= '0;
                act_q  <= next_div;
                sys_en <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                sys_en <= 1'b0;
            end
        end else begin
            sys_en <= 1'b0;
        end
    end
endmodule

// File: rtl/sclk_ctrl.sv
// Top of the system clock controller: resolves the effective configuration
// from the two words, then chains source select, loop model and divider.
// Assumes one clock domain; all rates are expressed as tick strobes.
module sclk_ctrl
    import sclk_pkg::*;
#(
    parameter int LOCK_TICKS = 16,
    parameter int INT_DIV    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              tick_xtal_i,
    input  logic              tick_int_i,
    input  logic              tick_lf30_i,
    input  logic              tick_lf32_i,
    output logic              sys_en_o,
    output logic              lock_irq_o
);
    localparam int KEY_W = 3 + XTAL_W;

    logic               a_byp, a_pd, a_udiv, b_ovr, b_byp, b_pd;
    logic [1:0]         a_src;
    logic [2:0]         b_src;
    logic [XTAL_W-1:0]  a_xtal;
    logic [DIV_A_W-1:0] a_div;
    logic [DIV_B_W-1:0] b_div;
    logic [MUL_W-1:0]   mul_f;
    logic [REF_W-1:0]   ref_r;
    logic               lock_sts;

    src_e               src_eff;
    logic [DIV_B_W-1:0] div_eff;
    logic               byp_eff, pd_eff, use_loop;
    logic               src_tick, loop_tick, locked, lock_rise, pre_tick;

    sclk_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i),
        .wdata(reg_wdata_i), .rdata(reg_rdata_o), .lock_set(lock_rise),
        .a_byp(a_byp), .a_pd(a_pd), .a_udiv(a_udiv), .a_src(a_src),
        .a_xtal(a_xtal), .a_div(a_div), .b_ovr(b_ovr), .b_byp(b_byp),
        .b_pd(b_pd), .b_src(b_src), .b_div(b_div), .mul_f(mul_f),
        .ref_r(ref_r), .lock_sts(lock_sts)
    );

    // Effective configuration: the second word overrides when enabled
    always_comb begin
        if (b_ovr) begin
            src_eff = (b_src >= 3'd4) ? SRC_LF32 : src_e'(b_src);
            div_eff = b_div;
            byp_eff = b_byp;
            pd_eff  = b_pd;
        end else begin
            src_eff = src_e'({1'b0, a_src});
            div_eff = DIV_B_W'(a_div);
            byp_eff = a_byp;
            pd_eff  = a_pd;
        end
    end

    // Bypass is forced while the loop is unlocked or powered down
    assign use_loop = !byp_eff && !pd_eff && locked;

    sclk_src_sel #(.INT_DIV(INT_DIV)) u_src (
        .clk(clk), .rst_n(rst_n), .sel(src_eff), .t_xtal(tick_xtal_i),
        .t_int(tick_int_i), .t_lf30(tick_lf30_i), .t_lf32(tick_lf32_i),
        .src_tick(src_tick)
    );

    sclk_loop_model #(
        .FW(MUL_W), .RW(REF_W), .KEY_W(KEY_W), .LOCK_TICKS(LOCK_TICKS)
    ) u_loop (
        .clk(clk), .rst_n(rst_n), .ref_tick(src_tick), .pd(pd_eff),
        .key({src_eff, a_xtal}), .mul_f(mul_f), .ref_r(ref_r),
        .loop_tick(loop_tick), .locked(locked), .lock_rise(lock_rise)
    );

    sclk_sysdiv #(.DW(DIV_B_W)) u_div (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .loop_tick(loop_tick),
        .use_loop(use_loop), .use_div(a_udiv), .div(div_eff),
        .pre_tick(pre_tick), .sys_en(sys_en_o)
    );

    assign lock_irq_o = lock_sts;
endmodule

// File: rtl/sclk_ctrl_chk.sv
// Checker for the system clock controller, bound into the top module.
// Relates register writes, lock state and the tick path over time.
module sclk_ctrl_chk #(
    parameter int XW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          lock_rise,
    input logic          locked,
    input logic          pd_eff,
    input logic [2:0]    src_eff,
    input logic [XW-1:0] xtal,
    input logic          pre_tick,
    input logic          src_tick,
    input logic          clr_hit
);
    // R6: the interrupt only rises after a lock event
    a_r6_irq_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(lock_rise));

    // R6: power-down drops lock
    a_r6_pd_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        pd_eff |=> !locked);

    // R9: source or crystal change drops lock
    a_r9_key_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(src_eff) || !$stable(xtal)) |=> !locked);

    // R7: write-one clear without a simultaneous lock event clears status
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !lock_rise) |=> !irq);

    // R8: unlocked loop never feeds the divider
    a_r8_raw_until_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && pre_tick) |-> src_tick);
endmodule

bind sclk_ctrl sclk_ctrl_chk #(.XW(sclk_pkg::XTAL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(lock_irq_o), .lock_rise(lock_rise),
    .locked(locked), .pd_eff(pd_eff), .src_eff(src_eff), .xtal(a_xtal),
    .pre_tick(pre_tick), .src_tick(src_tick),
    .clr_hit(reg_we_i && reg_addr_i == sclk_pkg::ADDR_STAT && reg_wdata_i[0])
);

// File: tb/sclk_ctrl_tb_top.sv
// Bench for the system clock controller: periodic source ticks, directed
// and seeded random configurations, strobe counts checked against rates.
module sclk_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LOCK_T     = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        t_x = 1'b0, t_i = 1'b0, t_l30 = 1'b0, t_l32 = 1'b0;
    logic        sys_en, irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int p_x = 4, p_i = 3, p_l30 = 7, p_l32 = 5;
    int ph_x = 0, ph_i = 0, ph_l30 = 0, ph_l32 = 0;
    int n_x = 0, n_i = 0, n_l30 = 0, n_l32 = 0, n_en = 0;
    int gap = 0, last_gap = 0;

    sclk_ctrl #(.LOCK_TICKS(LOCK_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_xtal_i(t_x),
        .tick_int_i(t_i), .tick_lf30_i(t_l30), .tick_lf32_i(t_l32),
        .sys_en_o(sys_en), .lock_irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick generation and counting, away from the active edge
    always @(negedge clk) begin
        n_x   += int'(t_x);
        n_i   += int'(t_i);
        n_l30 += int'(t_l30);
        n_l32 += int'(t_l32);
        gap   += 1;
        if (sys_en) begin
            n_en += 1;
            last_gap = gap;
            gap = 0;
        end
        t_x   <= (ph_x == 0);
        t_i   <= (ph_i == 0);
        t_l30 <= (ph_l30 == 0);
        t_l32 <= (ph_l32 == 0);
        ph_x   = (ph_x + 1 >= p_x) ? 0 : ph_x + 1;
        ph_i   = (ph_i + 1 >= p_i) ? 0 : ph_i + 1;
        ph_l30 = (ph_l30 + 1 >= p_l30) ? 0 : ph_l30 + 1;
        ph_l32 = (ph_l32 + 1 >= p_l32) ? 0 : ph_l32 + 1;
    end

    function automatic logic [31:0] cfg_a(bit byp, bit pd, bit udiv,
                                          int src, int xtal, int div);
        logic [31:0] w = '0;
        w[0] = byp; w[1] = pd; w[2] = udiv;
        w[4:3] = src[1:0]; w[8:5] = xtal[3:0]; w[15:12] = div[3:0];
        return w;
    endfunction

    function automatic logic [31:0] cfg_b(bit ovr, bit byp, bit pd,
                                          int src, int div);
        logic [31:0] w = '0;
        w[0] = byp; w[1] = pd; w[4:2] = src[2:0];
        w[21:16] = div[5:0]; w[31] = ovr;
        return w;
    endfunction

    function automatic int exp_raw(int n, int div);
        return n / (div + 1);
    endfunction

    function automatic int exp_loop(int n, int f, int r, int div);
        return (n * f) / (r + 1) / 2 / (div + 1);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_near(string tag, int act, int exp, int tol);
        check((act >= exp - tol) && (act <= exp + tol), tag, act, exp);
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_strobes(int k);
        int s;
        @(posedge clk); #1;
        s = n_en;
        for (int i = 0; i < 5000 && n_en < s + k; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_xticks(int k);
        int s;
        @(posedge clk); #1;
        s = n_x;
        for (int i = 0; i < 5000 && n_x < s + k; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // Measure source and strobe counts over a window of cycles
    task automatic measure(int cyc, int src, output int ns, output int ne);
        int sx, si, s30, s32, se;
        @(posedge clk); #1;
        sx = n_x; si = n_i; s30 = n_l30; s32 = n_l32; se = n_en;
        repeat (cyc) @(posedge clk);
        #1;
        case (src)
            0: ns = n_x - sx;
            1: ns = n_i - si;
            2: ns = (n_i - si) / 4;
            3: ns = n_l30 - s30;
            default: ns = n_l32 - s32;
        endcase
        ne = n_en - se;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int ns, ne, src, dv, ovr, ud, seed;

        seed = 32'd1234;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        #1;
        check(!sys_en && !irq, "R11 outputs low in reset", int'(sys_en), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R11: reset values
        rd(2'd0, d); check(d == 32'h0000000B, "R11 word0 reset", int'(d), 11);
        rd(2'd1, d); check(d == 32'h00000003, "R11 word1 reset", int'(d), 3);
        rd(2'd2, d); check(d == 32'h00000001, "R11 loop reset", int'(d), 1);
        rd(2'd3, d); check(d == 32'h00000000, "R11 status reset", int'(d), 0);

        // R2: each source raw and undivided
        for (int s = 0; s < 4; s++) begin
            wr(2'd0, cfg_a(1, 1, 0, s, 0, 0));
            wait_strobes(2);
            measure(240, s, ns, ne);
            check_near("R2 raw source rate", ne, ns, 2);
        end

        // R5: divider applied only with the use-divider bit
        wr(2'd0, cfg_a(1, 1, 1, 1, 0, 3));
        wait_strobes(2);
        measure(300, 1, ns, ne);
        check_near("R5 divide by 4", ne, exp_raw(ns, 3), 2);
        wr(2'd0, cfg_a(1, 1, 0, 1, 0, 3));
        wait_strobes(2);
        measure(300, 1, ns, ne);
        check_near("R5 divider ignored", ne, ns, 2);

        // R1: second word overrides source and divider, 32 kHz code
        wr(2'd0, cfg_a(1, 1, 1, 0, 0, 0));
        wr(2'd1, cfg_b(1, 1, 1, 4, 5));
        wait_strobes(2);
        measure(400, 4, ns, ne);
        check_near("R1 override source and divider", ne, exp_raw(ns, 5), 2);
        wr(2'd1, cfg_b(0, 1, 1, 4, 5));
        wait_strobes(2);
        measure(200, 0, ns, ne);
        check_near("R1 override off uses word0", ne, ns, 2);

        // R2 and R5: seeded random raw configurations
        for (int it = 0; it < 8; it++) begin
            ovr = $urandom % 2;
            ud  = $urandom % 2;
            dv  = $urandom % 6;
            if (ovr != 0) begin
                src = $urandom % 5;
                wr(2'd0, cfg_a(1, 1, ud[0], 0, 0, 0));
                wr(2'd1, cfg_b(1, 1, 1, src, dv));
            end else begin
                src = $urandom % 4;
                wr(2'd1, cfg_b(0, 1, 1, 0, 0));
                wr(2'd0, cfg_a(1, 1, ud[0], src, 0, dv));
            end
            wait_strobes(2);
            measure(600, src, ns, ne);
            check_near("R2 R5 random raw rate", ne,
                       exp_raw(ns, (ud != 0) ? dv : 0), 2);
        end
        wr(2'd1, cfg_b(0, 1, 1, 0, 0));

        // R10: divider change completes the running period first
        wr(2'd0, cfg_a(1, 1, 1, 1, 0, 7));
        wait_strobes(3);
        repeat (5) @(posedge clk);
        #1;
        wr(2'd0, cfg_a(1, 1, 1, 1, 0, 0));
        wait_strobes(1);
        check(last_gap == 24, "R10 old period completes", last_gap, 24);
        wait_strobes(1);
        check(last_gap == 3, "R10 new period after boundary", last_gap, 3);

        // R6: lock after power-down clears, bypass kept set
        wr(2'd2, 32'h0000_020A);
        wr(2'd0, cfg_a(1, 0, 1, 0, 0, 1));
        wait_xticks(LOCK_T - 3);
        check(!irq, "R6 no lock before count", int'(irq), 0);
        wait_xticks(6);
        check(irq, "R6 lock status set", int'(irq), 1);

        // R7: write-one clear, write-zero no effect
        wr(2'd3, 32'h0);
        @(posedge clk); #1;
        check(irq, "R7 write zero keeps status", int'(irq), 1);
        wr(2'd3, 32'h1);
        @(posedge clk); #1;
        check(!irq, "R7 write one clears", int'(irq), 0);

        // R3 and R4: loop path rates with and without the divider
        wr(2'd0, cfg_a(0, 0, 1, 0, 0, 1));
        wait_strobes(3);
        measure(480, 0, ns, ne);
        check_near("R3 R4 loop rate with divider", ne,
                   exp_loop(ns, 10, 2, 1), 3);
        wr(2'd0, cfg_a(0, 0, 0, 0, 0, 1));
        wait_strobes(3);
        measure(480, 0, ns, ne);
        check_near("R4 loop rate halved only", ne,
                   exp_loop(ns, 10, 2, 0), 3);

        // R9 and R8: crystal change drops lock, output falls back to raw
        wr(2'd0, cfg_a(0, 0, 0, 0, 5, 1));
        repeat (2) @(posedge clk);
        measure(40, 0, ns, ne);
        check_near("R8 raw while relocking", ne, ns, 2);
        check(!irq, "R9 status stays clear during restart", int'(irq), 0);
        wait_xticks(LOCK_T + 4);
        check(irq, "R9 relock after crystal change", int'(irq), 1);
        wr(2'd3, 32'h1);

        // R9: source change restarts lock as well
        wr(2'd0, cfg_a(0, 0, 0, 1, 5, 0));
        repeat (2) @(posedge clk);
        measure(30, 1, ns, ne);
        check_near("R9 raw after source change", ne, ns, 2);
        repeat (LOCK_T * 3 + 12) @(posedge clk);
        #1;
        check(irq, "R9 relock after source change", int'(irq), 1);

        // R8 and R6: bypass clear but powered down stays raw
        wr(2'd0, cfg_a(0, 1, 0, 0, 0, 0));
        wait_strobes(2);
        measure(300, 0, ns, ne);
        check_near("R8 power-down forces raw", ne, ns, 2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule